// File: doc/BRIEF.md
# Fractional PLL frequency calculator

This block works out the output frequency of a fractional-N PLL. It takes a 32-bit PLL control word and a reference frequency in hertz. From the word it pulls four fields: an integer multiplier, a signed fractional numerator, a denominator and a predivider. It then evaluates the frequency in 32-bit fixed-point arithmetic.

The low 10 bits of the reference are dropped before the multiply so that the product stays inside 32 bits. The result is shifted back up by 10 at the end, so the low 10 bits of every result are zero.

A caller pulses `start` with the word and the reference held valid on that cycle. One cycle later the block forms the numerator product. A 32-step sequential divider follows, and `done` then pulses together with the new `freq_out`. The block sits beside clock-control logic that needs derived frequencies, such as timer setup, where a result every few dozen cycles is enough.

Top module: `pll_freq_calc`

## Requirements
- R1: After reset, `done` is 0 and `freq_out` is 0.
- R2: The control word fields are numerator N = bits [9:0], multiplier I = bits [13:10], denominator field D = bits [25:16] and predivider field P = bits [29:26]. The result is ((2 × (ref >> 10) × (I × (D+1) + N)) / ((D+1) × (P+1))) << 10. Word 0x00001800 with a 26,000,000 Hz reference gives 311,992,320.
- R3: An I value below 5 is used as 5, so words with I = 0, 4 and 5 give identical results. Values of 5 and above are used unchanged.
- R4: N is a 10-bit two's-complement value, so 0x200 stands for -512 and 0x3FF for -1.
- R5: The denominator used is D+1 and the predivider used is P+1. D = 0 and P = 0 therefore divide by one, and the largest field values divide by 1024 and 16.
- R6: The numerator product is treated as signed 32-bit. The quotient truncates toward zero, so a negative product gives a negative result, returned as a two's-complement 32-bit word.
- R7: Bits [9:0] of `ref_freq` have no effect on the result, and bits [9:0] of `freq_out` are always 0 when `done` is high.
- R8: All products and the final shift wrap modulo 2^32.
- R9: `done` goes high exactly 35 clock edges after the edge that accepts `start`, counting the accepting edge as the first.
- R10: `done` is high for exactly one cycle. `freq_out` holds its value until the next result is delivered.
- R11: A `start` received while a calculation is in progress is ignored. The running result is unaffected and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation when idle |
| pll_word | input | 32 | PLL control word, sampled with start |
| ref_freq | input | 32 | Reference frequency in Hz, sampled with start |
| done | output | 1 | One-cycle pulse when freq_out is updated |
| freq_out | output | 32 | Computed output frequency in Hz |

## Verification
The formula is tried with several kinds of control word. The nominal word with a typical reference pins down the field positions. Multiplier values either side of the clamp threshold show whether the clamp exists and where it sits. Numerators at -512 and -1 separate sign extension from zero extension, and large D and P values with a non-dividing product expose an off-by-one in D+1 or P+1, or a wrong rounding direction. A reference whose low bits vary shows whether those bits are truly discarded, and an all-ones reference with maximum fields forces the 32-bit wrap. A start pulse issued mid-calculation with a different word shows whether the running result is protected.

// File: rtl/pll_freq_calc.sv
module pll_freq_calc #(
  parameter int W       = 32,
  parameter int SHIFT   = 10,
  parameter int MFI_MIN = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] pll_word,
  input  logic [W-1:0] ref_freq,
  output logic         done,
  output logic [W-1:0] freq_out
);
  localparam int NW  = 10;
  localparam int IW  = 4;
  localparam int DW  = 10;
  localparam int PW  = 4;
  localparam int CW  = $clog2(W);
  localparam int DVW = DW + 1 + PW + 1;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV, S_FIN} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [NW-1:0]   num_r;
  logic [IW-1:0]   mul_r;
  logic [DW:0]     den_r;
  logic [PW:0]     pdv_r;
  logic [W-SHIFT-1:0] ref_r;
  logic [W-1:0]    dvd;
  logic [W:0]      rem;
  logic [DVW-1:0]  dvs;
  logic            neg;

  logic [IW-1:0]   mul_c;
  logic [W-1:0]    term, prod, mag;
  logic [W:0]      rem_sh, rem_sub;
  logic [W-1:0]    quo_s;

  assign mul_c  = (pll_word[13:10] < IW'(MFI_MIN)) ? IW'(MFI_MIN) : pll_word[13:10];
  assign term   = W'(mul_r) * W'(den_r) + {{(W-NW){num_r[NW-1]}}, num_r};
  assign prod   = (W'(ref_r) << 1) * term;
  assign mag    = prod[W-1] ? (~prod + W'(1)) : prod;
  assign rem_sh = {rem[W-1:0], dvd[W-1]};
  assign rem_sub = rem_sh - (W+1)'(dvs);
  assign quo_s  = neg ? (~dvd + W'(1)) : dvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      num_r    <= '0;
      mul_r    <= '0;
      den_r    <= '0;
      pdv_r    <= '0;
      ref_r    <= '0;
      dvd      <= '0;
      rem      <= '0;
      dvs      <= '0;
      neg      <= 1'b0;
      done     <= 1'b0;
      freq_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          num_r <= pll_word[9:0];
          mul_r <= mul_c;
          den_r <= {1'b0, pll_word[25:16]} + (DW+1)'(1);
          pdv_r <= {1'b0, pll_word[29:26]} + (PW+1)'(1);
          ref_r <= ref_freq[W-1:SHIFT];
          st    <= S_MUL;
        end
        S_MUL: begin
          dvd <= mag;
          neg <= prod[W-1];
          rem <= '0;
          dvs <= DVW'(den_r) * DVW'(pdv_r);
          cnt <= '0;
          st  <= S_DIV;
        end
        S_DIV: begin
          if (rem_sub[W]) begin
            rem <= rem_sh;
            dvd <= {dvd[W-2:0], 1'b0};
          end else begin
            rem <= rem_sub;
            dvd <= {dvd[W-2:0], 1'b1};
          end
          cnt <= cnt + CW'(1);
          if (cnt == CW'(W-1)) st <= S_FIN;
        end
        default: begin
          freq_out <= quo_s << SHIFT;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int W   = 32,
  parameter int LAT = 34
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [W-1:0] freq_out
);
  logic       busy_c;
  logic [7:0] cnt_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
    end else if (done) begin
      busy_c <= start;
      cnt_c  <= '0;
    end else if (!busy_c && start) begin
      busy_c <= 1'b1;
      cnt_c  <= '0;
    end else if (busy_c && cnt_c != 8'hFF) begin
      cnt_c <= cnt_c + 8'd1;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(freq_out));

  // R9 R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_c && cnt_c == 8'(LAT)));

  // R7
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (freq_out[9:0] == 10'd0));
endmodule

bind pll_freq_calc pll_freq_calc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .freq_out(freq_out)
);

// File: tb/sim_pll_freq_calc.sv
module sim_pll_freq_calc;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pll_word = '0;
  logic [31:0] ref_freq = '0;
  logic        done;
  logic [31:0] freq_out;

  int checks = 0;
  int fails = 0;

  pll_freq_calc u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_word(pll_word),
    .ref_freq(ref_freq), .done(done), .freq_out(freq_out)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 150000);
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  function automatic logic [31:0] mkword(int p, int d, int i, int n);
    return {2'b00, 4'(p), 10'(d), 2'b00, 4'(i), 10'(n)};
  endfunction

  function automatic logic [31:0] model(logic [31:0] w, logic [31:0] r);
    int i, d, p, n, t, pr, q;
    i = int'(w[13:10]);
    if (i < 5) i = 5;
    d = int'(w[25:16]) + 1;
    p = int'(w[29:26]) + 1;
    n = int'($signed(w[9:0]));
    t = i * d + n;
    pr = 2 * int'(r >> 10) * t;
    q = pr / (d * p);
    return 32'(q) << 10;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] r,
                     output logic [31:0] res, output int lat);
    @(negedge clk);
    pll_word = w;
    ref_freq = r;
    start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk);
      #1;
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
    res = freq_out;
  endtask

  task automatic calc_check(string req, logic [31:0] w, logic [31:0] r);
    logic [31:0] res;
    int lat;
    run(w, r, res, lat);
    check(req, res, model(w, r));
  endtask

  task automatic t_reset;
    check("R1 done", 32'(done), 32'd0);
    check("R1 freq_out", freq_out, 32'd0);
  endtask

  task automatic t_nominal;
    logic [31:0] res;
    int lat;
    run(32'h0000_1800, 32'd26000000, res, lat);
    check("R2 nominal", res, 32'd311992320);
    check("R9 latency", 32'(lat), 32'd35);
    calc_check("R2 mixed fields", mkword(2, 3, 9, 17), 32'd24000000);
  endtask

  task automatic t_clamp;
    logic [31:0] r5, r0, r4;
    int lat;
    run(mkword(0, 0, 5, 0), 32'd26000000, r5, lat);
    run(mkword(0, 0, 0, 0), 32'd26000000, r0, lat);
    run(mkword(0, 0, 4, 0), 32'd26000000, r4, lat);
    check("R3 I=0 as 5", r0, r5);
    check("R3 I=4 as 5", r4, r5);
    calc_check("R3 I=15 kept", mkword(0, 0, 15, 0), 32'd26000000);
  endtask

  task automatic t_sign;
    calc_check("R4 N=-1", mkword(0, 7, 8, 10'h3FF), 32'd26000000);
    calc_check("R4 N=-512 negative", mkword(6, 0, 5, 10'h200), 32'd26000000);
  endtask

  task automatic t_divs;
    calc_check("R5 max D and P", mkword(15, 1023, 7, 100), 32'd19200000);
    calc_check("R6 truncate", mkword(4, 2, 6, 1), 32'd26000000);
  endtask

  task automatic t_neg;
    logic [31:0] res;
    int lat;
    run(mkword(6, 0, 5, 10'h200), 32'd26000000, res, lat);
    check("R6 negative value", res, 32'(-(int'(25745460 / 7))) << 10);
  endtask

  task automatic t_low_ref;
    logic [31:0] a, b;
    int lat;
    run(32'h0000_1800, 32'd26000000 & ~32'h3FF, a, lat);
    run(32'h0000_1800, (32'd26000000 & ~32'h3FF) | 32'h3FF, b, lat);
    check("R7 ref low bits ignored", b, a);
    check("R7 result low bits", 32'(a[9:0]), 32'd0);
  endtask

  task automatic t_wrap;
    calc_check("R8 wrap", mkword(0, 1023, 15, 511), 32'hFFFF_FFFF);
  endtask

  task automatic t_pulse_hold;
    logic [31:0] res;
    int lat;
    int extra = 0;
    run(mkword(1, 1, 7, 3), 32'd13000000, res, lat);
    @(posedge clk); #1;
    check("R10 done one cycle", 32'(done), 32'd0);
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (done || freq_out !== res) extra++;
    end
    check("R10 held", 32'(extra), 32'd0);
  endtask

  task automatic t_busy;
    logic [31:0] wa, wb;
    int lat = 0;
    int extra = 0;
    wa = mkword(0, 0, 6, 0);
    wb = mkword(3, 5, 11, 40);
    @(negedge clk);
    pll_word = wa; ref_freq = 32'd26000000; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; lat = 1;
    for (int k = 0; k < 9; k++) begin @(posedge clk); #1; lat++; end
    pll_word = wb; ref_freq = 32'd40000000; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; lat++;
    while (!done && lat < 100) begin @(posedge clk); #1; lat++; end
    check("R11 result of first start", freq_out, model(wa, 32'd26000000));
    check("R11 latency unchanged", 32'(lat), 32'd35);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (done) extra++;
    end
    check("R11 no extra done", 32'(extra), 32'd0);
  endtask

  initial begin
    #(PERIOD * 3 + 1);
    t_reset();
    rst_n = 1'b1;
    #(PERIOD * 2);
    t_reset();
    t_nominal();
    t_clamp();
    t_sign();
    t_divs();
    t_neg();
    t_low_ref();
    t_wrap();
    t_pulse_hold();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule